// File: doc/BRIEF.md
# Reloading Periodic Down-Counter Timer

This block is a small memory-mapped timer. Software programs a 16-bit reload value and sets an enable bit. From then on a down-counter steps once per microsecond and restarts from the reload value each time it runs out, emitting a one-clock expiry pulse per period. The microsecond step comes from an internal divider sized by the system clock frequency parameter.

Three word-wide registers sit in a 256-byte window: control at offset 0x00, reload at 0x08 and count at 0x0C. The enable bit (control bit 0) can only start the counter. It never stops it. A one in control bit 31 is not stored. Instead it wipes the block: the counter halts and the control, reload and count values all return to zero. The count register is read-only, and writes to it are dropped.

Top module: `reload_timer_top`

## Requirements
- R1: After the synchronous reset, control, reload and count all read zero, the counter is halted and `expire_o` is low.
- R2: A control write with bit 31 clear stores all 32 written bits, which read back unchanged. If bit 0 of the written value is one, the counter starts running.
- R3: A control write with bit 0 clear does not halt a running counter. Expiry pulses continue.
- R4: A control write with bit 31 set is not stored. It halts the counter and clears control, reload and count to zero, and the counter stays halted until bit 0 is written as one again.
- R5: A reload write keeps only bits 15:0. In the same clock it also loads the counter with that value, including while the counter is running.
- R6: A read of count returns the counter in bits 15:0, with bits 31:16 read as zero. A write to count changes nothing.
- R7: A running counter with a nonzero reload value R decrements once per tick, and one tick comes every CLK_HZ/TICK_HZ clocks. Consecutive expiry pulses are therefore exactly R*CLK_HZ/TICK_HZ clocks apart.
- R8: When a running counter at 1 receives a tick, it reloads on that tick and `expire_o` is high for exactly one clock, in the clock that follows.
- R9: Only offsets 0x00, 0x08 and 0x0C are mapped. A read of any other offset, including a misaligned one, returns zero, and a write to it has no effect.
- R10: With a reload value of zero, the count stays at zero and no expiry pulse is produced, even while the counter is enabled.
- R11: `bus_rdata` carries the read value in the clock after `bus_rd` is high, and it is zero in a clock that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one clock per read |
| bus_rdata | output | 32 | Read data, valid one clock after the strobe |
| expire_o | output | 1 | One-clock pulse at each counter expiry |

## Verification
A wrong run flag shows up quickly at the ports. If the counter is halted when it should run, or runs when it should be halted, expiry pulses are missing or appear within one period, which is at most reload × divider clocks. A wrong count or reload register appears in the next read, and it also shifts the spacing between pulses by whole tick intervals. A wrong divider shows as a period error of reload clocks per tick of miscount. Each of these is caught by measuring the exact spacing between pulses.

// File: rtl/rtmr_pkg.sv
`timescale 1ns/1ps
package rtmr_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_RELOAD = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_COUNT  = 8'h0C;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_RST_BIT = 31;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_RELOAD,
        SEL_COUNT
    } reg_sel_e;

    typedef struct packed {
        logic             wipe;
        logic             start;
        logic             load;
        logic [CNT_W-1:0] load_val;
    } cnt_cmd_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFF_CTRL:   s = SEL_CTRL;
            OFF_RELOAD: s = SEL_RELOAD;
            OFF_COUNT:  s = SEL_COUNT;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] zext_cnt(input logic [CNT_W-1:0] v);
        return {{(DATA_W-CNT_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/rtmr_tick_gen.sv
`timescale 1ns/1ps
module rtmr_tick_gen #(
    parameter int CLK_HZ  = 200_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int RAW_DIV = CLK_HZ / TICK_HZ;
    localparam int DIV     = (RAW_DIV < 1) ? 1 : RAW_DIV;

    generate
        if (DIV == 1) begin : g_every
            logic live_q;
            always_ff @(posedge clk) begin
                if (rst) live_q <= 1'b0;
                else     live_q <= 1'b1;
            end
            assign tick_o = live_q;
        end else begin : g_div
            localparam int CW = $clog2(DIV);
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst)                         cnt_q <= '0;
                else if (cnt_q == CW'(DIV - 1))  cnt_q <= '0;
                else                             cnt_q <= cnt_q + 1'b1;
            end
            assign tick_o = (cnt_q == CW'(DIV - 1));
        end
    endgenerate
endmodule

// File: rtl/rtmr_regs.sv
`timescale 1ns/1ps
module rtmr_regs
    import rtmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  count_i,
    output cnt_cmd_t          cmd_o,
    output logic [DATA_W-1:0] ctrl_o,
    output logic [CNT_W-1:0]  reload_o
);
    reg_sel_e          sel;
    logic              ctrl_wr, wipe_req;
    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    logic [DATA_W-1:0] rdata_q;

    assign sel      = decode_addr(addr);
    assign ctrl_wr  = wr && (sel == SEL_CTRL);
    assign wipe_req = ctrl_wr && wdata[CTRL_RST_BIT];

    always_ff @(posedge clk) begin
        if (rst || wipe_req) begin
            ctrl_q   <= '0;
            reload_q <= '0;
        end else begin
            if (ctrl_wr)                  ctrl_q   <= wdata;
            if (wr && sel == SEL_RELOAD)  reload_q <= wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        cmd_o          = '0;
        cmd_o.wipe     = wipe_req;
        cmd_o.start    = ctrl_wr && !wdata[CTRL_RST_BIT] && wdata[CTRL_EN_BIT];
        cmd_o.load     = wr && (sel == SEL_RELOAD);
        cmd_o.load_val = wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst || !rd) begin
            rdata_q <= '0;
        end else begin
            case (sel)
                SEL_CTRL:   rdata_q <= ctrl_q;
                SEL_RELOAD: rdata_q <= zext_cnt(reload_q);
                SEL_COUNT:  rdata_q <= zext_cnt(count_i);
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign rdata    = rdata_q;
    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;
endmodule

// File: rtl/rtmr_counter.sv
`timescale 1ns/1ps
module rtmr_counter
    import rtmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  cnt_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] count_q;
    logic             run_q;
    logic             expire_q;
    logic             step;

    assign step = run_q && tick_i && (reload_i != '0);

    always_ff @(posedge clk) begin
        if (rst || cmd_i.wipe) begin
            count_q  <= '0;
            run_q    <= 1'b0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= 1'b0;
            if (cmd_i.start) run_q <= 1'b1;
            if (cmd_i.load) begin
                count_q <= cmd_i.load_val;
            end else if (step) begin
                if (count_q <= CNT_W'(1)) begin
                    count_q  <= reload_i;
                    expire_q <= 1'b1;
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
        end
    end

    assign count_o   = count_q;
    assign running_o = run_q;
    assign expire_o  = expire_q;
endmodule

// File: rtl/reload_timer_top.sv
`timescale 1ns/1ps
module reload_timer_top
    import rtmr_pkg::*;
#(
    parameter int CLK_HZ  = 200_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    input  logic        bus_rd,
    output logic [31:0] bus_rdata,
    output logic        expire_o
);
    logic              tick_w;
    cnt_cmd_t          cmd_w;
    logic [DATA_W-1:0] ctrl_w;
    logic [CNT_W-1:0]  reload_w;
    logic [CNT_W-1:0]  count_w;
    logic              running_w;

    rtmr_tick_gen #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) tick_i (
        .clk    (clk),
        .rst    (rst),
        .tick_o (tick_w)
    );

    rtmr_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .rd       (bus_rd),
        .rdata    (bus_rdata),
        .count_i  (count_w),
        .cmd_o    (cmd_w),
        .ctrl_o   (ctrl_w),
        .reload_o (reload_w)
    );

    rtmr_counter cnt_i (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_w),
        .cmd_i     (cmd_w),
        .reload_i  (reload_w),
        .count_o   (count_w),
        .running_o (running_w),
        .expire_o  (expire_o)
    );
endmodule

// File: rtl/rtmr_checker.sv
`timescale 1ns/1ps
module rtmr_checker
    import rtmr_pkg::*;
#(
    parameter int CLK_HZ  = 200_000_000,
    parameter int TICK_HZ = 1_000_000
) (
    input logic              clk,
    input logic              rst,
    input logic [7:0]        bus_addr,
    input logic              bus_wr,
    input logic [31:0]       bus_wdata,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic              expire,
    input logic              tick,
    input logic [DATA_W-1:0] ctrl_q,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  count_q,
    input logic              running
);
    localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;

    logic mapped;
    assign mapped = (bus_addr == OFF_CTRL) || (bus_addr == OFF_RELOAD) ||
                    (bus_addr == OFF_COUNT);

    p_wipe_clears_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_CTRL && bus_wdata[31]) |=>
        (ctrl_q == '0 && reload_q == '0 && count_q == '0 && !running));

    p_no_stop_r3: assert property (@(posedge clk) disable iff (rst)
        (running && !(bus_wr && bus_addr == OFF_CTRL && bus_wdata[31])) |=> running);

    p_reload_loads_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_RELOAD) |=>
        (count_q == $past(bus_wdata[15:0]) && reload_q == $past(bus_wdata[15:0])));

    p_count_hi_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFF_COUNT) |=> (bus_rdata[31:16] == 16'h0));

    p_count_wr_dropped_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == OFF_COUNT && !tick) |=> $stable(count_q));

    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (DIV > 1 && expire) |=> !expire);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !mapped) |=> (bus_rdata == '0));

    p_zero_reload_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (reload_q == '0) |=> !expire);

    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
endmodule

bind reload_timer_top rtmr_checker #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .expire    (expire_o),
    .tick      (tick_w),
    .ctrl_q    (ctrl_w),
    .reload_q  (reload_w),
    .count_q   (count_w),
    .running   (running_w)
);

// File: tb/reload_timer_top_tb_top.sv
`timescale 1ns/1ps
module reload_timer_top_tb_top;
    localparam int CLK_HZ  = 8_000_000;
    localparam int TICK_HZ = 1_000_000;
    localparam int DIV     = CLK_HZ / TICK_HZ;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        expire_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    reload_timer_top #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .expire_o  (expire_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected read value, monitor compares it
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // Monitor
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected read data", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    // Counts negedges until expire_o is seen or the limit runs out
    task automatic wait_expire(input int limit, output int n, output bit found);
        found = 1'b0;
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            if (expire_o === 1'b1) begin
                found = 1'b1;
                break;
            end
        end
    endtask

    task automatic finish_run();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 32'h1, 32'h0);
            finish_run();
        end
    end

    initial begin
        int  n;
        bit  found;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check(expire_o === 1'b0, "R1 expire low after reset", {31'h0, expire_o}, 32'h0);
        check(bus_rdata === 32'h0, "R11 idle read data zero", bus_rdata, 32'h0);
        rd(8'h00, 32'h0, "R1 control after reset");
        rd(8'h08, 32'h0, "R1 reload after reset");
        rd(8'h0C, 32'h0, "R1 count after reset");
        wait_expire(10 * DIV, n, found);
        check(!found, "R1 no expiry after reset", {31'h0, found}, 32'h0);

        // R5/R6: reload masks upper bits and loads count
        wr(8'h08, 32'hABCD_1234);
        rd(8'h08, 32'h0000_1234, "R5 reload keeps low 16 bits");
        rd(8'h0C, 32'h0000_1234, "R6 count reads loaded value, upper zero");
        wr(8'h0C, 32'h0000_0055);
        rd(8'h0C, 32'h0000_1234, "R6 count write dropped");

        // R9: unmapped and misaligned
        rd(8'h04, 32'h0, "R9 unmapped 0x04 reads zero");
        rd(8'h0D, 32'h0, "R9 misaligned 0x0D reads zero");
        rd(8'h80, 32'h0, "R9 unmapped 0x80 reads zero");
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h09, 32'h0000_0077);
        rd(8'h08, 32'h0000_1234, "R9 reload unaffected by stray writes");
        rd(8'h00, 32'h0, "R9 control unaffected by stray writes");

        // R2: store without enable, counter stays halted
        wr(8'h00, 32'h1234_56F0);
        rd(8'h00, 32'h1234_56F0, "R2 control stores full word");
        repeat (5 * DIV) @(posedge clk);
        rd(8'h0C, 32'h0000_1234, "R2 counter not started without enable");

        // R7/R8: periodic operation with reload 5
        wr(8'h08, 32'h0000_0005);
        wr(8'h00, 32'h0000_0001);
        rd(8'h00, 32'h0000_0001, "R2 control with enable stored");
        wait_expire(20 * DIV, n, found);
        check(found, "R7 first expiry after start", {31'h0, found}, 32'h1);
        @(negedge clk);
        check(expire_o === 1'b0, "R8 pulse one clock wide", {31'h0, expire_o}, 32'h0);
        wait_expire(20 * DIV, n, found);
        check(found && n == 5 * DIV - 1, "R7 period equals reload times divider",
              n + 1, 5 * DIV);
        @(negedge clk);
        check(expire_o === 1'b0, "R8 second pulse one clock wide", {31'h0, expire_o}, 32'h0);
        wait_expire(20 * DIV, n, found);
        check(found && n == 5 * DIV - 1, "R8 periodic pulses repeat", n + 1, 5 * DIV);

        // R3: enable clear does not halt
        wr(8'h00, 32'h0000_0000);
        rd(8'h00, 32'h0, "R3 control reads zero");
        wait_expire(8 * DIV, n, found);
        check(found, "R3 still expiring after enable clear", {31'h0, found}, 32'h1);

        // R5: reload while running loads immediately
        wr(8'h08, 32'h0000_0003);
        wait_expire(20 * DIV, n, found);
        check(found && n <= 3 * DIV + 2, "R5 new reload takes effect at once", n, 3 * DIV);
        @(negedge clk);
        wait_expire(20 * DIV, n, found);
        check(found && n == 3 * DIV - 1, "R5 period follows new reload", n + 1, 3 * DIV);

        // R4: wipe
        wr(8'h00, 32'h8000_0001);
        rd(8'h00, 32'h0, "R4 control cleared, value not stored");
        rd(8'h08, 32'h0, "R4 reload cleared");
        rd(8'h0C, 32'h0, "R4 count cleared");
        wr(8'h08, 32'h0000_0004);
        wait_expire(10 * DIV, n, found);
        check(!found, "R4 counter halted after wipe", {31'h0, found}, 32'h0);
        rd(8'h0C, 32'h0000_0004, "R4 count frozen while halted");

        // R10: zero reload
        wr(8'h08, 32'h0000_0000);
        wr(8'h00, 32'h0000_0001);
        wait_expire(20 * DIV, n, found);
        check(!found, "R10 no expiry with zero reload", {31'h0, found}, 32'h0);
        rd(8'h0C, 32'h0, "R10 count stays zero");

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R11 all reads answered", exp_q.size(), 32'h0);
        done = 1'b1;
        finish_run();
    end
endmodule